// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit keeps four 16-bit segment base registers and turns a 16-bit offset into a 20-bit physical address. The address is the selected segment value moved up by four bit positions, so every segment begins on a 16-byte boundary, plus the offset. Because segment starts are only 16 bytes apart, many segment:offset pairs can name the same physical byte.

A requester states what kind of access it is making: an instruction fetch, a stack access, a source-string access or a destination-string access. The unit picks the segment register that belongs to that kind. For stack and source-string accesses, an override input can substitute any of the four registers. The selected register index is reported next to the address.

Segment registers are written through a single write port and read back through a separate read port. They are never used as arithmetic operands. The address path is combinational from the registered segment state, so a write shows up in the address in the cycle after the clock edge that captures it.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset every segment register reads back as 0000h, and every access produces a physical address equal to the offset.
- R2: The physical address equals (segment × 16) + offset, truncated to 20 bits. For example, segment A43Fh with offset 3487h gives A7877h, and the low four address bits always equal the low four offset bits.
- R3: A carry out of bit 19 is dropped. Segment FFFFh with offset 0010h gives 00000h, and segment FFFFh with offset FFFFh gives 0FFEFh.
- R4: An instruction fetch (accKind = 0) always uses the code register (index 0), whatever the override inputs hold.
- R5: A stack access (accKind = 1) uses the stack register (index 2) when ovrValid is 0, and the register named by ovrSeg when ovrValid is 1.
- R6: A source-string access (accKind = 2) uses the data register (index 1) when ovrValid is 0, and the register named by ovrSeg when ovrValid is 1.
- R7: A destination-string access (accKind = 3) always uses the extra register (index 3), whatever the override inputs hold.
- R8: When segWrEn is high at a rising clock edge, the register named by segWrIdx takes segWrData. The other three registers keep their values. segRdData shows the register named by segRdIdx without delay.
- R9: A segment write reaches physAddr and segRdData only after the capturing edge. During the cycle that carries the write, the old value is still used.
- R10: segUsed reports the index (code = 0, data = 1, stack = 2, extra = 3) of the register that formed physAddr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 2 | Register to write (0 code, 1 data, 2 stack, 3 extra) |
| segWrData | input | 16 | Value to load |
| segRdIdx | input | 2 | Register to read back |
| segRdData | output | 16 | Read-back value |
| accKind | input | 2 | Access kind (0 fetch, 1 stack, 2 source string, 3 destination string) |
| offset | input | 16 | Offset within the segment |
| ovrValid | input | 1 | Override enable for stack and source-string accesses |
| ovrSeg | input | 2 | Register used when the override applies |
| physAddr | output | 20 | Physical address |
| segUsed | output | 2 | Index of the register that formed physAddr |

## Verification
The assertions check on every cycle the rules that hold at any instant:
- fetch and destination-string accesses pin their segment choice;
- stack and source-string accesses follow the override;
- the low address nibble matches the offset;
- a write lands in the next cycle and an idle cycle leaves the read-back stable;
- registers are zero right after reset.

Only the bench's scenarios can show the full address sum for every access kind and override setting against independently loaded register contents. The same holds for the wrap past 20 bits, for the fact that a write leaves the other registers untouched, and for the one-cycle lag between a write and its effect on the address.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEGS  = 4;
  localparam int SEG_IDX_W = $clog2(NUM_SEGS);

  typedef enum logic [SEG_IDX_W-1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } segIdx_e;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_STACK = 2'd1,
    KIND_SRC   = 2'd2,
    KIND_DST   = 2'd3
  } accKind_e;

  typedef struct packed {
    logic [NUM_SEGS-1:0] loadStrb;
    segIdx_e             addrSel;
  } ctrlStrb_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrIdx,
  input  logic [1:0]           accKind,
  input  logic                 ovrValid,
  input  logic [SEG_IDX_W-1:0] ovrSeg,
  output ctrlStrb_t            ctrl
);
  segIdx_e defaultSel;
  logic    ovrAllowed;

  always_comb begin
    ovrAllowed = 1'b0;
    unique case (accKind_e'(accKind))
      KIND_FETCH: defaultSel = SEG_CODE;
      KIND_STACK: begin defaultSel = SEG_STACK; ovrAllowed = 1'b1; end
      KIND_SRC:   begin defaultSel = SEG_DATA;  ovrAllowed = 1'b1; end
      default:    defaultSel = SEG_EXTRA;
    endcase
  end

  assign ctrl.addrSel = (ovrAllowed && ovrValid) ? segIdx_e'(ovrSeg) : defaultSel;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_strb
    assign ctrl.loadStrb[g] = segWrEn && (segWrIdx == SEG_IDX_W'(g));
  end
endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PHYS_W = SEG_W + SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            ctrl,
  input  logic [SEG_W-1:0]     segWrData,
  input  logic [SEG_IDX_W-1:0] segRdIdx,
  input  logic [OFF_W-1:0]     offset,
  output logic [SEG_W-1:0]     segRdData,
  output logic [PHYS_W-1:0]    physAddr
);
  logic [SEG_W-1:0]  segReg [NUM_SEGS];
  logic [SEG_W-1:0]  selSeg;
  logic [PHYS_W-1:0] segBase;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 segReg[g] <= '0;
      else if (ctrl.loadStrb[g]) segReg[g] <= segWrData;
    end
  end

  assign segRdData = segReg[segRdIdx];
  assign selSeg    = segReg[ctrl.addrSel];
  assign segBase   = {selSeg, {SHIFT{1'b0}}};
  assign physAddr  = segBase + PHYS_W'(offset);
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PHYS_W = SEG_W + SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrIdx,
  input  logic [SEG_W-1:0]     segWrData,
  input  logic [SEG_IDX_W-1:0] segRdIdx,
  output logic [SEG_W-1:0]     segRdData,
  input  logic [1:0]           accKind,
  input  logic [OFF_W-1:0]     offset,
  input  logic                 ovrValid,
  input  logic [SEG_IDX_W-1:0] ovrSeg,
  output logic [PHYS_W-1:0]    physAddr,
  output logic [SEG_IDX_W-1:0] segUsed
);
  ctrlStrb_t ctrl;

  seg_addr_ctrl u_ctrl (
    .segWrEn  (segWrEn),
    .segWrIdx (segWrIdx),
    .accKind  (accKind),
    .ovrValid (ovrValid),
    .ovrSeg   (ovrSeg),
    .ctrl     (ctrl)
  );

  seg_addr_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .segWrData (segWrData),
    .segRdIdx  (segRdIdx),
    .offset    (offset),
    .segRdData (segRdData),
    .physAddr  (physAddr)
  );

  assign segUsed = ctrl.addrSel;
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PHYS_W = SEG_W + SHIFT
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 segWrEn,
  input logic [SEG_IDX_W-1:0] segWrIdx,
  input logic [SEG_W-1:0]     segWrData,
  input logic [SEG_IDX_W-1:0] segRdIdx,
  input logic [SEG_W-1:0]     segRdData,
  input logic [1:0]           accKind,
  input logic [OFF_W-1:0]     offset,
  input logic                 ovrValid,
  input logic [SEG_IDX_W-1:0] ovrSeg,
  input logic [PHYS_W-1:0]    physAddr,
  input logic [SEG_IDX_W-1:0] segUsed
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> segRdData == '0);

  p_low_nibble_r2: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[SHIFT-1:0] == offset[SHIFT-1:0]);

  p_fetch_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'd0 |-> segUsed == 2'd0);

  p_stack_sel_r5: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'd1 |-> segUsed == (ovrValid ? ovrSeg : 2'd2));

  p_src_sel_r6: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'd2 |-> segUsed == (ovrValid ? ovrSeg : 2'd1));

  p_dst_extra_r7: assert property (@(posedge clk) disable iff (!rstN)
    accKind == 2'd3 |-> segUsed == 2'd3);

  p_write_lands_r8: assert property (@(posedge clk) disable iff (!rstN)
    (segWrEn && segWrIdx == segRdIdx) |=>
      (segRdIdx != $past(segRdIdx)) || (segRdData == $past(segWrData)));

  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !segWrEn |=> (segRdIdx != $past(segRdIdx)) || $stable(segRdData));
endmodule

bind seg_addr_unit seg_addr_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_chk (
  .clk(clk), .rstN(rstN), .segWrEn(segWrEn), .segWrIdx(segWrIdx),
  .segWrData(segWrData), .segRdIdx(segRdIdx), .segRdData(segRdData),
  .accKind(accKind), .offset(offset), .ovrValid(ovrValid), .ovrSeg(ovrSeg),
  .physAddr(physAddr), .segUsed(segUsed)
);

// File: tb/seg_addr_unit_bench.sv
`timescale 1ns/1ps
module seg_addr_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrIdx = '0;
  logic [15:0] segWrData = '0;
  logic [1:0]  segRdIdx = '0;
  logic [15:0] segRdData;
  logic [1:0]  accKind = '0;
  logic [15:0] offset = '0;
  logic        ovrValid = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic [19:0] physAddr;
  logic [1:0]  segUsed;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [15:0] model [4];

  always #5 clk = ~clk;

  seg_addr_unit u_seg_addr_unit (
    .clk(clk), .rstN(rstN), .segWrEn(segWrEn), .segWrIdx(segWrIdx),
    .segWrData(segWrData), .segRdIdx(segRdIdx), .segRdData(segRdData),
    .accKind(accKind), .offset(offset), .ovrValid(ovrValid), .ovrSeg(ovrSeg),
    .physAddr(physAddr), .segUsed(segUsed)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] addrOf(logic [15:0] s, logic [15:0] o);
    logic [20:0] full = {1'b0, s, 4'h0} + {5'h0, o};
    return full[19:0];
  endfunction

  function automatic logic [1:0] selOf(logic [1:0] k, logic ov, logic [1:0] os);
    case (k)
      2'd0: return 2'd0;
      2'd1: return ov ? os : 2'd2;
      2'd2: return ov ? os : 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  task automatic writeSeg(logic [1:0] idx, logic [15:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
    model[idx] = val;
  endtask

  task automatic probe(string req, logic [1:0] k, logic ov, logic [1:0] os, logic [15:0] o);
    logic [1:0] s;
    accKind = k; ovrValid = ov; ovrSeg = os; offset = o;
    #1;
    s = selOf(k, ov, os);
    check(req, 32'(segUsed), 32'(s));
    check(req, 32'(physAddr), 32'(addrOf(model[s], o)));
  endtask

  task automatic sweep();
    logic [15:0] offs [5] = '{16'h0000, 16'h3487, 16'hFFFF, 16'h0010, 16'h8001};
    for (int k = 0; k < 4; k++)
      for (int ov = 0; ov < 2; ov++)
        for (int os = 0; os < 4; os++)
          for (int i = 0; i < 5; i++)
            probe(k == 0 ? "R4 R10" : k == 1 ? "R5 R2" : k == 2 ? "R6 R2" : "R7 R3",
                  2'(k), 1'(ov), 2'(os), offs[i]);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      segRdIdx = 2'(i); #1;
      check("R1 readback", 32'(segRdData), 32'h0);
    end
    probe("R1 address", 2'd2, 1'b0, 2'd0, 16'h1234);
    check("R1 offset only", 32'(physAddr), 32'h01234);

    // R2: worked example through the data register
    writeSeg(2'd1, 16'hA43F);
    probe("R2 example", 2'd2, 1'b0, 2'd0, 16'h3487);
    check("R2 A7877", 32'(physAddr), 32'hA7877);

    // R3: wrap past 20 bits through the extra register
    writeSeg(2'd3, 16'hFFFF);
    probe("R3 wrap", 2'd3, 1'b0, 2'd0, 16'h0010);
    check("R3 zero", 32'(physAddr), 32'h00000);
    probe("R3 wrap max", 2'd3, 1'b0, 2'd0, 16'hFFFF);
    check("R3 0FFEF", 32'(physAddr), 32'h0FFEF);

    // R8: write one register, the others keep their values
    writeSeg(2'd0, 16'h1357);
    writeSeg(2'd2, 16'h2468);
    for (int i = 0; i < 4; i++) begin
      segRdIdx = 2'(i); #1;
      check("R8 readback", 32'(segRdData), 32'(model[i]));
    end

    // R9: same-cycle write not yet visible
    @(negedge clk);
    accKind = 2'd0; ovrValid = 1'b0; offset = 16'h0005; segRdIdx = 2'd0;
    segWrEn = 1'b1; segWrIdx = 2'd0; segWrData = 16'hBEEF;
    #1;
    check("R9 old addr", 32'(physAddr), 32'(addrOf(16'h1357, 16'h0005)));
    check("R9 old read", 32'(segRdData), 32'h1357);
    @(negedge clk);
    segWrEn = 1'b0; model[0] = 16'hBEEF;
    #1;
    check("R9 new addr", 32'(physAddr), 32'(addrOf(16'hBEEF, 16'h0005)));
    check("R9 new read", 32'(segRdData), 32'hBEEF);

    // Full sweeps with two register loadings
    sweep();
    writeSeg(2'd0, 16'h0001);
    writeSeg(2'd1, 16'h8000);
    writeSeg(2'd2, 16'hF00F);
    writeSeg(2'd3, 16'h7FFE);
    sweep();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule